// File: doc/BRIEF.md
# Channel Busy Percentage Estimator

This block turns a set of free-running hardware counters into a set of occupancy figures. The counters are an elapsed-cycle count, a control-channel busy count, an extension-channel busy count, a receive-frame count and a transmit-frame count. On a sample request it takes a snapshot of all five counters. It subtracts the snapshot kept from the previous request and reports, for each activity, the whole-number percentage of elapsed cycles spent in that activity.

It also estimates how busy the extension channel is. This figure is measured against the time the control channel was clear, not against total time, because the extension indication means nothing while the control channel is busy. The counters right-shift when they overflow rather than wrap. A cycle count that moves backwards therefore cannot be turned into a figure, and the result is flagged invalid.

All quotients come from one shared restoring divider, so the work is done in sequence. A single-cycle `done` pulse marks the moment when every output has been updated together.

Top module: `chan_busy_est`

## Requirements
- R1: After a synchronous reset all percentage outputs, `ext_ratio`, `valid` and `done` are 0. The stored snapshot is zero, so the first completed sample after reset reports `valid`=0 with every figure 0.
- R2: The four activity counters are taken in the clock cycle where `sample_req` is accepted. The cycle counter is taken one clock later.
- R3: For a valid sample, each of `pct_ctl`, `pct_ext`, `pct_rx` and `pct_tx` equals floor(activity delta × 100 / cycle delta). The result saturates at 255.
- R4: The clear time is defined as cycle delta − control delta when the cycle delta is strictly larger, and 0 otherwise. `ext_ratio` = floor(extension delta × 100 / clear time), clamped to at most 100. It is 100 when the clear time is 0.
- R5: If the new cycle count is below the stored one, the sample reports `valid`=0, every percentage 0 and `ext_ratio` 0.
- R6: If the new cycle count equals the stored one (cycle delta zero), the sample reports `valid`=0 with every figure 0.
- R7: After every sample, valid or not, all five taken values replace the stored snapshot.
- R8: `done` is high for exactly one cycle per accepted sample. The outputs change only in the cycle where `done` is high and hold their values otherwise.
- R9: A `sample_req` that arrives while a sample is still being computed is ignored. It neither restarts the computation nor touches the stored snapshot.
- R10: Deltas are taken modulo 2^32, so an activity counter that passes 0xFFFFFFFF yields the true difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_req | input | 1 | Request a new snapshot (accepted when idle) |
| cnt_cycle | input | 32 | Free-running elapsed-cycle counter |
| cnt_ctl | input | 32 | Control-channel busy counter |
| cnt_ext | input | 32 | Extension-channel busy counter |
| cnt_rx | input | 32 | Receive-frame counter |
| cnt_tx | input | 32 | Transmit-frame counter |
| pct_ctl | output | 8 | Control busy percentage |
| pct_ext | output | 8 | Extension busy percentage of total time |
| pct_rx | output | 8 | Receive-frame percentage |
| pct_tx | output | 8 | Transmit-frame percentage |
| ext_ratio | output | 8 | Extension busy relative to control clear time, 0..100 |
| valid | output | 1 | Figures of the latest sample are meaningful |
| done | output | 1 | One-cycle pulse when all outputs have been updated |

## Verification
The assertions assume that `rst` is asserted for at least one clock before the first `sample_req`. They place no condition on the counter values: the divider is never started with a zero divisor, whatever the counters do. The stimulus changes counters and the request only on the falling clock edge. It issues one request per sample except in the single overlapping-request scenario. The activity deltas are kept near or below the cycle delta, apart from the cases that deliberately drive the saturation and clamp paths.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int N_ACT     = 4;   // activity channels: ctl, ext, rx, tx
  localparam int IDX_CTL   = 0;
  localparam int IDX_EXT   = 1;
  localparam int IDX_RX    = 2;
  localparam int IDX_TX    = 3;
  localparam int N_QUOT    = N_ACT + 1; // last quotient is the extension ratio
  localparam int SCALE     = 100;
  localparam int SCALE_W   = 7;   // bits needed to hold SCALE

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRAB,
    ST_WAIT,
    ST_LOAD,
    ST_RUN,
    ST_FIN
  } cbp_state_e;
endpackage

// File: rtl/cbp_snapshot.sv
module cbp_snapshot
  import cbp_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_act,
  input  logic          take_cyc,
  input  logic [CW-1:0] cnt_cycle,
  input  logic [CW-1:0] act_in  [N_ACT],
  output logic [CW-1:0] d_cyc,
  output logic [CW-1:0] d_act   [N_ACT],
  output logic          snap_ok,
  output logic          snap_evt
);
  logic [CW-1:0] prev_cyc;
  logic          first_smp, backwards, standstill;

  function automatic logic [CW-1:0] f_delta(input logic [CW-1:0] now_v,
                                           input logic [CW-1:0] old_v);
    return now_v - old_v; // modulo 2^CW
  endfunction

  assign first_smp  = (prev_cyc == '0);
  assign backwards  = (prev_cyc > cnt_cycle);
  assign standstill = (prev_cyc == cnt_cycle);

  // activity channels: captured at the strobe, folded at cycle capture
  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    logic [CW-1:0] cur_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q    <= '0;
        prev_q   <= '0;
        d_act[g] <= '0;
      end else begin
        if (take_act) cur_q <= act_in[g];
        if (take_cyc) begin
          d_act[g] <= f_delta(cur_q, prev_q);
          prev_q   <= cur_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cyc <= '0;
      d_cyc    <= '0;
      snap_ok  <= 1'b0;
      snap_evt <= 1'b0;
    end else begin
      snap_evt <= take_cyc;
      if (take_cyc) begin
        d_cyc    <= f_delta(cnt_cycle, prev_cyc);
        snap_ok  <= !(first_smp || backwards || standstill);
        prev_cyc <= cnt_cycle;
      end
    end
  end

  // R2: the cycle counter is never taken without an activity capture just before
  assert_cyc_after_act_R2: assert property (@(posedge clk) disable iff (rst)
    take_cyc |-> $past(take_act));
endmodule

// File: rtl/cbp_divider.sv
module cbp_divider #(
  parameter int NW = 39,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] numer,
  input  logic [DW-1:0] denom,
  output logic [NW-1:0] quot,
  output logic          busy,
  output logic          done
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [NW-1:0]    num_q, numer_q;
  logic [DW-1:0]    rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW:0]      shifted, diff;
  logic             fits;

  assign shifted = {rem_q, num_q[NW-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign fits    = (shifted >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q   <= '0;
      numer_q <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        num_q   <= numer;
        numer_q <= numer;
        den_q   <= denom;
        rem_q   <= '0;
        cnt_q   <= CNT_W'(NW);
        busy    <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
        num_q <= {num_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = num_q;

  // R3: the quotient and remainder reconstruct the dividend exactly
  assert_quot_exact_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{DW{1'b0}}, num_q} * {{NW{1'b0}}, den_q}) + {{NW{1'b0}}, rem_q}
              == {{DW{1'b0}}, numer_q}));
  assert_rem_below_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < den_q));
endmodule

// File: rtl/cbp_ctrl.sv
module cbp_ctrl
  import cbp_pkg::*;
#(
  parameter int CW    = 32,
  parameter int PCT_W = 8,
  parameter int NW    = CW + SCALE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_req,
  input  logic             snap_evt,
  input  logic             snap_ok,
  input  logic [CW-1:0]    d_cyc,
  input  logic [CW-1:0]    d_act [N_ACT],
  input  logic             div_busy,
  input  logic             div_done,
  input  logic [NW-1:0]    div_quot,
  output logic             take_act,
  output logic             take_cyc,
  output logic             div_start,
  output logic [NW-1:0]    div_num,
  output logic [CW-1:0]    div_den,
  output logic [PCT_W-1:0] pct_out [N_ACT],
  output logic [PCT_W-1:0] ext_ratio,
  output logic             valid,
  output logic             done
);
  localparam int              IDX_W    = $clog2(N_QUOT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_QUOT - 1);
  localparam logic [PCT_W-1:0] PCT_MAX  = '1;
  localparam logic [PCT_W-1:0] CLAMP    = PCT_W'(SCALE);

  cbp_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PCT_W-1:0] res_q [N_QUOT];
  logic             ok_q;
  logic [CW-1:0]    clear_d;
  logic             clear_zero;
  logic             on_ratio;

  function automatic logic [NW-1:0] f_scale(input logic [CW-1:0] d);
    return {{(NW-CW){1'b0}}, d} * NW'(SCALE);
  endfunction

  function automatic logic [PCT_W-1:0] f_sat(input logic [NW-1:0] q,
                                            input logic [PCT_W-1:0] lim);
    return (q > NW'(lim)) ? lim : q[PCT_W-1:0];
  endfunction

  function automatic logic [CW-1:0] f_clear(input logic [CW-1:0] cyc,
                                           input logic [CW-1:0] ctl);
    return (cyc > ctl) ? (cyc - ctl) : '0;
  endfunction

  assign clear_d    = f_clear(d_cyc, d_act[IDX_CTL]);
  assign clear_zero = (clear_d == '0);
  assign on_ratio   = (idx_q == LAST_IDX);

  assign take_act  = (state_q == ST_IDLE) && sample_req;
  assign take_cyc  = (state_q == ST_GRAB);
  assign div_start = (state_q == ST_LOAD) && !(on_ratio && clear_zero);

  always_comb begin
    div_num = f_scale(d_act[IDX_EXT]);
    div_den = clear_d;
    if (!on_ratio) begin
      div_num = f_scale(d_act[idx_q[1:0]]);
      div_den = d_cyc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      ok_q      <= 1'b0;
      valid     <= 1'b0;
      done      <= 1'b0;
      ext_ratio <= '0;
      for (int i = 0; i < N_QUOT; i++) res_q[i] <= '0;
      for (int i = 0; i < N_ACT; i++) pct_out[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (sample_req) state_q <= ST_GRAB;
        ST_GRAB: state_q <= ST_WAIT;
        ST_WAIT: if (snap_evt) begin
          ok_q <= snap_ok;
          idx_q <= '0;
          if (snap_ok) state_q <= ST_LOAD;
          else begin
            for (int i = 0; i < N_QUOT; i++) res_q[i] <= '0;
            state_q <= ST_FIN;
          end
        end
        ST_LOAD: begin
          if (on_ratio && clear_zero) begin
            res_q[idx_q] <= CLAMP;
            state_q      <= ST_FIN;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (div_done) begin
          res_q[idx_q] <= on_ratio ? f_sat(div_quot, CLAMP) : f_sat(div_quot, PCT_MAX);
          if (on_ratio) state_q <= ST_FIN;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_FIN: begin
          for (int i = 0; i < N_ACT; i++) pct_out[i] <= res_q[i];
          ext_ratio <= res_q[LAST_IDX];
          valid     <= ok_q;
          done      <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: the divider is never started while it is still working
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    div_start |-> !div_busy);
  // R6: an accepted snapshot always carries a nonzero cycle delta
  assert_nonzero_span_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && snap_evt && snap_ok) |-> (d_cyc != '0));
endmodule

// File: rtl/chan_busy_est.sv
module chan_busy_est
  import cbp_pkg::*;
#(
  parameter int CW    = 32,
  parameter int PCT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_req,
  input  logic [CW-1:0]    cnt_cycle,
  input  logic [CW-1:0]    cnt_ctl,
  input  logic [CW-1:0]    cnt_ext,
  input  logic [CW-1:0]    cnt_rx,
  input  logic [CW-1:0]    cnt_tx,
  output logic [PCT_W-1:0] pct_ctl,
  output logic [PCT_W-1:0] pct_ext,
  output logic [PCT_W-1:0] pct_rx,
  output logic [PCT_W-1:0] pct_tx,
  output logic [PCT_W-1:0] ext_ratio,
  output logic             valid,
  output logic             done
);
  localparam int NW = CW + SCALE_W;

  logic [CW-1:0]    act_in [N_ACT];
  logic [CW-1:0]    d_act  [N_ACT];
  logic [CW-1:0]    d_cyc;
  logic [PCT_W-1:0] pct_out [N_ACT];
  logic             take_act, take_cyc, snap_ok, snap_evt;
  logic             div_start, div_busy, div_done;
  logic [NW-1:0]    div_num, div_quot;
  logic [CW-1:0]    div_den;

  assign act_in[IDX_CTL] = cnt_ctl;
  assign act_in[IDX_EXT] = cnt_ext;
  assign act_in[IDX_RX]  = cnt_rx;
  assign act_in[IDX_TX]  = cnt_tx;

  cbp_snapshot #(.CW(CW)) u_snap (
    .clk(clk), .rst(rst), .take_act(take_act), .take_cyc(take_cyc),
    .cnt_cycle(cnt_cycle), .act_in(act_in), .d_cyc(d_cyc), .d_act(d_act),
    .snap_ok(snap_ok), .snap_evt(snap_evt)
  );

  cbp_divider #(.NW(NW), .DW(CW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .numer(div_num), .denom(div_den),
    .quot(div_quot), .busy(div_busy), .done(div_done)
  );

  cbp_ctrl #(.CW(CW), .PCT_W(PCT_W), .NW(NW)) u_ctrl (
    .clk(clk), .rst(rst), .sample_req(sample_req), .snap_evt(snap_evt),
    .snap_ok(snap_ok), .d_cyc(d_cyc), .d_act(d_act), .div_busy(div_busy),
    .div_done(div_done), .div_quot(div_quot), .take_act(take_act),
    .take_cyc(take_cyc), .div_start(div_start), .div_num(div_num),
    .div_den(div_den), .pct_out(pct_out), .ext_ratio(ext_ratio),
    .valid(valid), .done(done)
  );

  assign pct_ctl = pct_out[IDX_CTL];
  assign pct_ext = pct_out[IDX_EXT];
  assign pct_rx  = pct_out[IDX_RX];
  assign pct_tx  = pct_out[IDX_TX];

  // R5/R6/R1: an invalid result carries only zeros
  assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !valid) |-> (pct_ctl == '0 && pct_ext == '0 && pct_rx == '0 &&
                          pct_tx == '0 && ext_ratio == '0));
  // R4: the extension ratio never exceeds 100
  assert_ratio_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (ext_ratio <= PCT_W'(SCALE)));
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: outputs hold between completions
  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pct_ctl) && $stable(pct_ext) && $stable(pct_rx) &&
               $stable(pct_tx) && $stable(ext_ratio) && $stable(valid)));
endmodule

// File: tb/chan_busy_est_tb.sv
module chan_busy_est_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_req = 1'b0;
  logic [31:0] cnt_cycle = '0, cnt_ctl = '0, cnt_ext = '0, cnt_rx = '0, cnt_tx = '0;
  logic [7:0]  pct_ctl, pct_ext, pct_rx, pct_tx, ext_ratio;
  logic        valid, done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model of the stored snapshot
  logic [31:0] m_cyc = '0, m_ctl = '0, m_ext = '0, m_rx = '0, m_tx = '0;
  logic [31:0] e_ctl, e_ext, e_rx, e_tx, e_ratio;
  logic        e_valid;

  always #4 clk = ~clk; // 125 MHz

  chan_busy_est u_dut (
    .clk(clk), .rst(rst), .sample_req(sample_req), .cnt_cycle(cnt_cycle),
    .cnt_ctl(cnt_ctl), .cnt_ext(cnt_ext), .cnt_rx(cnt_rx), .cnt_tx(cnt_tx),
    .pct_ctl(pct_ctl), .pct_ext(pct_ext), .pct_rx(pct_rx), .pct_tx(pct_tx),
    .ext_ratio(ext_ratio), .valid(valid), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_pct(input logic [31:0] d, input logic [31:0] c);
    logic [63:0] q;
    q = ({32'd0, d} * 64'd100) / {32'd0, c};
    return (q > 64'd255) ? 32'd255 : q[31:0];
  endfunction

  // expected results from the model, then model update (R7)
  task automatic predict(input logic [31:0] ctl, ext, rx, tx, cyc);
    logic [31:0] dc, dctl, dext, drx, dtx, clr;
    logic [63:0] r;
    e_valid = (m_cyc != 0) && (cyc > m_cyc);
    dc = cyc - m_cyc; dctl = ctl - m_ctl; dext = ext - m_ext;
    drx = rx - m_rx; dtx = tx - m_tx;
    if (e_valid) begin
      e_ctl = f_pct(dctl, dc); e_ext = f_pct(dext, dc);
      e_rx = f_pct(drx, dc);   e_tx = f_pct(dtx, dc);
      clr = (dc > dctl) ? dc - dctl : 32'd0;
      if (clr == 0) e_ratio = 100;
      else begin
        r = ({32'd0, dext} * 64'd100) / {32'd0, clr};
        e_ratio = (r > 64'd100) ? 32'd100 : r[31:0];
      end
    end else begin
      e_ctl = 0; e_ext = 0; e_rx = 0; e_tx = 0; e_ratio = 0;
    end
    m_cyc = cyc; m_ctl = ctl; m_ext = ext; m_rx = rx; m_tx = tx;
  endtask

  // strobe: activity values now, decoy cycle value now, real cycle one clock later (R2)
  task automatic drive(input logic [31:0] ctl, ext, rx, tx, cyc);
    @(negedge clk);
    cnt_ctl = ctl; cnt_ext = ext; cnt_rx = rx; cnt_tx = tx;
    cnt_cycle = cyc ^ 32'h0055_0000; sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0; cnt_cycle = cyc;
    cnt_ctl = ~ctl; cnt_ext = ~ext; cnt_rx = ~rx; cnt_tx = ~tx;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk({req, " done seen"}, {31'd0, seen}, 32'd1);
  endtask

  task automatic check_out(input string req);
    chk({req, " valid"}, {31'd0, valid}, {31'd0, e_valid});
    chk({req, " pct_ctl"}, {24'd0, pct_ctl}, e_ctl);
    chk({req, " pct_ext"}, {24'd0, pct_ext}, e_ext);
    chk({req, " pct_rx"},  {24'd0, pct_rx},  e_rx);
    chk({req, " pct_tx"},  {24'd0, pct_tx},  e_tx);
    chk({req, " ext_ratio"}, {24'd0, ext_ratio}, e_ratio);
  endtask

  task automatic run_sample(input string req, input logic [31:0] ctl, ext, rx, tx, cyc);
    predict(ctl, ext, rx, tx, cyc);
    drive(ctl, ext, rx, tx, cyc);
    wait_done(req);
    check_out(req);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {31'd0, valid}, 0);
    chk("R1 reset done", {31'd0, done}, 0);
    chk("R1 reset pct_ctl", {24'd0, pct_ctl}, 0);
    chk("R1 reset ext_ratio", {24'd0, ext_ratio}, 0);
  endtask

  task automatic t_first;   run_sample("R1 first", 100, 50, 70, 30, 1000); endtask
  task automatic t_basic;   run_sample("R3 R2 basic", 2600, 1050, 3070, 1264, 11000); endtask
  task automatic t_clamp;   run_sample("R4 clamp", 11600, 4050, 3170, 1264, 21000); endtask
  task automatic t_clear0;  run_sample("R4 clear zero", 17600, 4060, 3180, 1270, 26000); endtask
  task automatic t_sat;     run_sample("R3 saturate", 17601, 4061, 6180, 1271, 27000); endtask

  task automatic t_wrap;
    run_sample("R10 pre", 32'hFFFF_FF00, 4070, 6190, 1280, 28000);
    run_sample("R10 wrap", 32'h0000_0100, 4170, 6290, 1380, 29000);
  endtask

  task automatic t_back;
    run_sample("R5 backwards", 32'h0000_0200, 4180, 6300, 1390, 500);
    run_sample("R7 after invalid", 32'h0000_0300, 4380, 6500, 1490, 1500);
  endtask

  task automatic t_still;   run_sample("R6 zero span", 32'h0000_0310, 4390, 6510, 1500, 1500); endtask

  task automatic t_hold;
    logic [7:0] h_ctl, h_ratio;
    logic       h_valid;
    run_sample("R8 base", 32'h0000_0400, 4400, 6600, 1600, 2500);
    h_ctl = pct_ctl; h_ratio = ext_ratio; h_valid = valid;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 done low", {31'd0, done}, 0);
      chk("R8 hold pct_ctl", {24'd0, pct_ctl}, {24'd0, h_ctl});
      chk("R8 hold ratio", {24'd0, ext_ratio}, {24'd0, h_ratio});
      chk("R8 hold valid", {31'd0, valid}, {31'd0, h_valid});
    end
  endtask

  task automatic t_ignored;
    predict(32'h0000_0500, 4500, 6700, 1700, 3500);
    drive(32'h0000_0500, 4500, 6700, 1700, 3500);
    repeat (20) @(negedge clk);
    cnt_ctl = 32'h0001_0000; cnt_ext = 32'h0002_0000; cnt_rx = 32'h0003_0000;
    cnt_tx = 32'h0004_0000; cnt_cycle = 32'h0010_0000; sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
    wait_done("R9 ignored");
    check_out("R9 ignored");
    run_sample("R9 next", 32'h0000_0600, 4600, 6800, 1800, 4500);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first();
    t_basic();
    t_clamp();
    t_clear0();
    t_sat();
    t_wrap();
    t_back();
    t_still();
    t_hold();
    t_ignored();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule